// File: doc/BRIEF.md
# Energy Pulse Generator

This block converts a stream of signed per-sample power words into a train of output pulses, one pulse per fixed quantum of energy, together with a direction indication for negative energy. Each sample is corrected by a signed offset, scaled by a programmable pulse-rate factor and accumulated. Whenever the accumulated magnitude reaches one quantum, one quantum is removed and a pulse is emitted.

The pin stage has four variants. In the plain variant each pulse is one clock long. In the counter-drive variant each pulse is stretched over a set number of sample periods, and further requests wait until the current pulse ends. In the manual variant the pins follow two user bits. An open-drain option can be combined with any of them. Status flags report the latest pulse, its direction and accumulator overrun. An optional anti-creep rule discards the accumulated residue after a run of samples without a pulse.

Top module: `energy_pulse_gen`

## Requirements
- R1: The power word and the offset are signed fractions with PWR_W-1 fractional bits. The rate has 5 fractional bits. Each sample adds (power + offset) × rate in raw units to a signed accumulator. One quantum is 2^(PWR_W-1+5) raw units. At the defaults, (power + offset) = 0x4000 with rate 32 (1.0) gives one pulse every second sample.
- R2: A rate value above RATE_CAP (default 256, meaning 8.0) is handled exactly as RATE_CAP.
- R3: A sample produces at most one pulse. When the accumulator magnitude is one quantum or more, one quantum is taken off toward zero, and the pulse status is set. Between samples the accumulator magnitude stays below one quantum.
- R4: The direction pin and the direction status are set together with a pulse when the accumulated value that produced the pulse is negative. The direction pin is never high without the pulse pin, except in manual mode.
- R5: The pulse and direction statuses clear on the next sample that produces no pulse. The host can also clear them with st_clr bit 0 (pulse) and bit 1 (direction). A status that is being set in the same cycle as a clear stays set.
- R6: If a sample leaves the accumulator magnitude at two quanta or more, the overrun status is set. A pulse is still emitted, and the accumulator is saturated to one quantum minus one raw unit, with the sign kept. The overrun status stays set until st_clr bit 2 is written.
- R7: In plain mode (mech_en=0, ovr_en=0) a pulse drives the pulse pin high for exactly one clock, in the cycle after the clock edge that takes the sample.
- R8: In counter-drive mode (mech_en=1) a pulse starts one clock after its request. It stays high until width_cfg further sample strobes have been taken, and it ends at the edge of the last of them. A width of 0 acts as 1.
- R9: In counter-drive mode, a request that arrives while a stretched pulse is active is held and launched as soon as that pulse ends.
- R10: With ovr_en=1 the pulse pin follows ovr_pulse and the direction pin follows ovr_dir, regardless of the energy logic. Manual mode has priority over counter-drive mode.
- R11: With odrain_en=1 both pin data outputs are 0. Each output enable is high only while the pin's logical value is 0.
- R12: With creep_en=1, the creep_lim-th consecutive sample without a pulse clears the accumulator instead of adding to it, so a steady load below 1/creep_lim quantum per sample never produces a pulse.
- R13: After reset the pins are low with enables high, and all status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-clock strobe, one per power sample |
| pwr_in | input | PWR_W | Signed power sample |
| pwr_ofs | input | PWR_W | Signed offset added to every sample |
| rate_cfg | input | RATE_W | Unsigned pulse-rate factor, 5 fractional bits |
| width_cfg | input | PWID_W | Stretched pulse length in sample periods |
| creep_lim | input | CREEP_W | Samples without a pulse before the residue is dropped |
| mech_en | input | 1 | Counter-drive (stretched pulse) mode |
| ovr_en | input | 1 | Manual pin mode |
| ovr_pulse | input | 1 | Manual value for the pulse pin |
| ovr_dir | input | 1 | Manual value for the direction pin |
| odrain_en | input | 1 | Open-drain pin drive |
| creep_en | input | 1 | Anti-creep enable |
| st_clr | input | 3 | Host clear: bit0 pulse, bit1 direction, bit2 overrun |
| epin_o | output | 1 | Pulse pin data |
| epin_oe | output | 1 | Pulse pin output enable |
| dpin_o | output | 1 | Direction pin data |
| dpin_oe | output | 1 | Direction pin output enable |
| st_pulse | output | 1 | Pulse status |
| st_dir | output | 1 | Direction status |
| st_oor | output | 1 | Accumulator overrun status |

## Verification
On every cycle the assertions check four things: the residue bound of the accumulator, the pairing of the direction pin with the pulse pin, that plain pulses appear only right after a sample, and that stretched pulses end only on a sample strobe. They also check that the overrun flag rises only after an overrun sample, and that open-drain pins never drive high. The directed scenarios show the arithmetic itself: pulse spacing for given power, offset and rate values, the rate clamp, the saturation value after an overrun, the anti-creep discard, stretched pulse length and the held request, and the host clears.

// File: rtl/epg_pkg.sv
package epg_pkg;
  typedef enum logic [1:0] {
    PM_NORM = 2'd0,
    PM_MECH = 2'd1,
    PM_OVR  = 2'd2
  } epg_pinmode_e;

  localparam int CLR_PULSE = 0;
  localparam int CLR_DIR   = 1;
  localparam int CLR_OOR   = 2;
  localparam int CLR_W     = 3;
endpackage

// File: rtl/epg_accum.sv
module epg_accum #(
  parameter int W        = 16,
  parameter int RW       = 12,
  parameter int FRAC     = 5,
  parameter int RATE_CAP = 256,
  parameter int CW       = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic [W-1:0]         pwr_in,
  input  logic [W-1:0]         pwr_ofs,
  input  logic [RW-1:0]        rate_cfg,
  input  logic                 creep_en,
  input  logic [CW-1:0]        creep_lim,
  output logic                 ev_valid,
  output logic                 ev_fire,
  output logic                 ev_neg,
  output logic                 ev_over
);
  localparam int SW  = W + 1;
  localparam int PW  = SW + RW + 1;
  localparam int QSH = W - 1 + FRAC;
  localparam int AW  = PW + 2;
  localparam logic [AW-1:0] ONE_A = {{(AW-1){1'b0}}, 1'b1};
  localparam logic signed [AW-1:0] QV  = $signed(ONE_A << QSH);
  localparam logic signed [AW-1:0] QV2 = $signed(ONE_A << (QSH + 1));
  localparam logic signed [AW-1:0] QM1 = QV - $signed(ONE_A);
  localparam logic [RW-1:0] CAP = RW'(RATE_CAP);
  localparam logic [CW-1:0] IDLE_MAX = {CW{1'b1}};

  logic signed [AW-1:0] acc_q, acc_d, nxt, mag, inc_x;
  logic signed [SW-1:0] psum;
  logic signed [PW-1:0] psum_x, rate_x, inc;
  logic [RW-1:0]        rate_eff;
  logic [CW-1:0]        idle_q, idle_d;
  logic [CW:0]          idle_inc;
  logic                 neg, fire, over, creep_hit;
  logic                 vld_d, fire_d, neg_d, over_d;

  always_comb begin
    psum     = $signed({pwr_in[W-1], pwr_in}) + $signed({pwr_ofs[W-1], pwr_ofs});
    rate_eff = (rate_cfg > CAP) ? CAP : rate_cfg;
    psum_x   = {{(PW-SW){psum[SW-1]}}, psum};
    rate_x   = {{(PW-RW){1'b0}}, rate_eff};
    inc      = psum_x * rate_x;
    inc_x    = {{(AW-PW){inc[PW-1]}}, inc};
    nxt      = acc_q + inc_x;
    neg      = nxt[AW-1];
    mag      = neg ? -nxt : nxt;
    fire     = (mag >= QV);
    over     = (mag >= QV2);
    idle_inc = {1'b0, idle_q} + {{CW{1'b0}}, 1'b1};
    creep_hit = creep_en && !fire && (idle_inc >= {1'b0, creep_lim});

    acc_d  = acc_q;
    idle_d = idle_q;
    vld_d  = smp_stb;
    fire_d = 1'b0;
    neg_d  = 1'b0;
    over_d = 1'b0;
    if (smp_stb) begin
      fire_d = fire;
      neg_d  = fire && neg;
      over_d = over;
      if (over) begin
        acc_d  = neg ? -QM1 : QM1;
        idle_d = '0;
      end else if (fire) begin
        acc_d  = neg ? (nxt + QV) : (nxt - QV);
        idle_d = '0;
      end else if (creep_hit) begin
        acc_d  = '0;
        idle_d = '0;
      end else begin
        acc_d  = nxt;
        idle_d = (idle_q == IDLE_MAX) ? idle_q : idle_inc[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      idle_q   <= '0;
      ev_valid <= 1'b0;
      ev_fire  <= 1'b0;
      ev_neg   <= 1'b0;
      ev_over  <= 1'b0;
    end else begin
      if (smp_stb) begin
        acc_q  <= acc_d;
        idle_q <= idle_d;
      end
      ev_valid <= vld_d;
      ev_fire  <= fire_d;
      ev_neg   <= neg_d;
      ev_over  <= over_d;
    end
  end

  // R3: residue stays strictly inside one quantum between samples
  a_r3_residue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q < QV) && (acc_q > -QV));
endmodule

// File: rtl/epg_status.sv
module epg_status
  import epg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic             ev_fire,
  input  logic             ev_neg,
  input  logic             ev_over,
  input  logic [CLR_W-1:0] st_clr,
  output logic             st_pulse,
  output logic             st_dir,
  output logic             st_oor
);
  logic pulse_d, dir_d, oor_d;

  always_comb begin
    pulse_d = st_pulse;
    dir_d   = st_dir;
    oor_d   = st_oor;
    if (st_clr[CLR_PULSE]) pulse_d = 1'b0;
    if (st_clr[CLR_DIR])   dir_d   = 1'b0;
    if (st_clr[CLR_OOR])   oor_d   = 1'b0;
    if (ev_valid) begin
      pulse_d = ev_fire;
      dir_d   = ev_fire && ev_neg;
      if (ev_over) oor_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_pulse <= 1'b0;
      st_dir   <= 1'b0;
      st_oor   <= 1'b0;
    end else begin
      st_pulse <= pulse_d;
      st_dir   <= dir_d;
      st_oor   <= oor_d;
    end
  end

  // R6: overrun flag only rises after an overrunning sample
  a_r6_oor_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_oor) |-> $past(ev_valid && ev_over));
endmodule

// File: rtl/epg_pins.sv
module epg_pins
  import epg_pkg::*;
#(
  parameter int PWW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_stb,
  input  logic           ev_valid,
  input  logic           ev_fire,
  input  logic           ev_neg,
  input  logic [PWW-1:0] width_cfg,
  input  logic           mech_en,
  input  logic           ovr_en,
  input  logic           ovr_pulse,
  input  logic           ovr_dir,
  input  logic           odrain_en,
  output logic           epin_o,
  output logic           epin_oe,
  output logic           dpin_o,
  output logic           dpin_oe
);
  localparam logic [PWW-1:0] ONE_W = {{(PWW-1){1'b0}}, 1'b1};

  epg_pinmode_e   mode;
  logic           req, p_val, d_val;
  logic           act_q, act_d, adir_q, adir_d, pend_q, pend_d, pdir_q, pdir_d;
  logic [PWW-1:0] rem_q, rem_d, wid_eff;

  always_comb begin
    mode    = ovr_en ? PM_OVR : (mech_en ? PM_MECH : PM_NORM);
    req     = ev_valid && ev_fire;
    wid_eff = (width_cfg == '0) ? ONE_W : width_cfg;

    act_d  = act_q;
    rem_d  = rem_q;
    adir_d = adir_q;
    pend_d = pend_q;
    pdir_d = pdir_q;
    if (mode != PM_MECH) begin
      act_d  = 1'b0;
      pend_d = 1'b0;
      rem_d  = '0;
    end else if (!act_q && (pend_q || req)) begin
      act_d  = 1'b1;
      rem_d  = wid_eff;
      adir_d = pend_q ? pdir_q : ev_neg;
      pend_d = pend_q && req;
      pdir_d = ev_neg;
    end else if (act_q) begin
      if (smp_stb) begin
        if (rem_q <= ONE_W) act_d = 1'b0;
        else                rem_d = rem_q - ONE_W;
      end
      if (req) begin
        pend_d = 1'b1;
        if (!pend_q) pdir_d = ev_neg;
      end
    end

    case (mode)
      PM_MECH: begin p_val = act_q;     d_val = act_q && adir_q; end
      PM_OVR:  begin p_val = ovr_pulse; d_val = ovr_dir;         end
      default: begin p_val = req;       d_val = req && ev_neg;   end
    endcase

    epin_o  = odrain_en ? 1'b0 : p_val;
    epin_oe = odrain_en ? !p_val : 1'b1;
    dpin_o  = odrain_en ? 1'b0 : d_val;
    dpin_oe = odrain_en ? !d_val : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rem_q  <= '0;
      adir_q <= 1'b0;
      pend_q <= 1'b0;
      pdir_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      rem_q  <= rem_d;
      adir_q <= adir_d;
      pend_q <= pend_d;
      pdir_q <= pdir_d;
    end
  end

  // R4: direction pin only accompanies a pulse outside manual mode
  a_r4_dir_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != PM_OVR && d_val) |-> p_val);
  // R7: plain pulses follow a sample strobe by one clock
  a_r7_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_NORM && p_val) |-> $past(smp_stb));
  // R8: a stretched pulse only ends on a sample strobe
  a_r8_end_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_MECH && $past(mode == PM_MECH) && $fell(act_q)) |-> $past(smp_stb));
  // R11: open-drain pins never drive high
  a_r11_odrain_low: assert property (@(posedge clk) disable iff (!rst_n)
    odrain_en |-> (!epin_o && !dpin_o));
endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen
  import epg_pkg::*;
#(
  parameter int PWR_W    = 16,
  parameter int RATE_W   = 12,
  parameter int RATE_CAP = 256,
  parameter int PWID_W   = 10,
  parameter int CREEP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [PWR_W-1:0]  pwr_in,
  input  logic [PWR_W-1:0]  pwr_ofs,
  input  logic [RATE_W-1:0] rate_cfg,
  input  logic [PWID_W-1:0] width_cfg,
  input  logic [CREEP_W-1:0] creep_lim,
  input  logic              mech_en,
  input  logic              ovr_en,
  input  logic              ovr_pulse,
  input  logic              ovr_dir,
  input  logic              odrain_en,
  input  logic              creep_en,
  input  logic [CLR_W-1:0]  st_clr,
  output logic              epin_o,
  output logic              epin_oe,
  output logic              dpin_o,
  output logic              dpin_oe,
  output logic              st_pulse,
  output logic              st_dir,
  output logic              st_oor
);
  localparam int RATE_FRAC = 5;

  logic [1:0] rs_q;
  logic       rst_s;
  logic       ev_valid, ev_fire, ev_neg, ev_over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  epg_accum #(
    .W(PWR_W), .RW(RATE_W), .FRAC(RATE_FRAC), .RATE_CAP(RATE_CAP), .CW(CREEP_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_s), .smp_stb(smp_stb), .pwr_in(pwr_in), .pwr_ofs(pwr_ofs),
    .rate_cfg(rate_cfg), .creep_en(creep_en), .creep_lim(creep_lim),
    .ev_valid(ev_valid), .ev_fire(ev_fire), .ev_neg(ev_neg), .ev_over(ev_over)
  );

  epg_status u_status (
    .clk(clk), .rst_n(rst_s), .ev_valid(ev_valid), .ev_fire(ev_fire), .ev_neg(ev_neg),
    .ev_over(ev_over), .st_clr(st_clr), .st_pulse(st_pulse), .st_dir(st_dir), .st_oor(st_oor)
  );

  epg_pins #(.PWW(PWID_W)) u_pins (
    .clk(clk), .rst_n(rst_s), .smp_stb(smp_stb), .ev_valid(ev_valid), .ev_fire(ev_fire),
    .ev_neg(ev_neg), .width_cfg(width_cfg), .mech_en(mech_en), .ovr_en(ovr_en),
    .ovr_pulse(ovr_pulse), .ovr_dir(ovr_dir), .odrain_en(odrain_en),
    .epin_o(epin_o), .epin_oe(epin_oe), .dpin_o(dpin_o), .dpin_oe(dpin_oe)
  );
endmodule

// File: tb/test_energy_pulse_gen.sv
module test_energy_pulse_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_stb;
  logic [15:0] pwr_in, pwr_ofs;
  logic [11:0] rate_cfg;
  logic [9:0]  width_cfg;
  logic [7:0]  creep_lim;
  logic        mech_en, ovr_en, ovr_pulse, ovr_dir, odrain_en, creep_en;
  logic [2:0]  st_clr;
  logic        epin_o, epin_oe, dpin_o, dpin_oe, st_pulse, st_dir, st_oor;

  int total = 0;
  int bad   = 0;
  bit mid_p, mid_d, end_p, end_d;

  always #10 clk = ~clk;

  energy_pulse_gen i_energy_pulse_gen (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .pwr_in(pwr_in), .pwr_ofs(pwr_ofs),
    .rate_cfg(rate_cfg), .width_cfg(width_cfg), .creep_lim(creep_lim), .mech_en(mech_en),
    .ovr_en(ovr_en), .ovr_pulse(ovr_pulse), .ovr_dir(ovr_dir), .odrain_en(odrain_en),
    .creep_en(creep_en), .st_clr(st_clr), .epin_o(epin_o), .epin_oe(epin_oe),
    .dpin_o(dpin_o), .dpin_oe(dpin_oe), .st_pulse(st_pulse), .st_dir(st_dir), .st_oor(st_oor)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; smp_stb = 1'b0; pwr_in = '0; pwr_ofs = '0; rate_cfg = 12'd32;
    width_cfg = 10'd2; creep_lim = 8'd0; mech_en = 1'b0; ovr_en = 1'b0;
    ovr_pulse = 1'b0; ovr_dir = 1'b0; odrain_en = 1'b0; creep_en = 1'b0; st_clr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // one sample; mid_* taken the cycle after the sampling edge, end_* two cycles later
  task automatic smp(input logic [15:0] p, input logic [15:0] o);
    @(negedge clk);
    smp_stb = 1'b1; pwr_in = p; pwr_ofs = o;
    @(negedge clk);
    smp_stb = 1'b0;
    mid_p = epin_o; mid_d = dpin_o;
    repeat (2) @(negedge clk);
    end_p = epin_o; end_d = dpin_o;
  endtask

  task automatic host_clr(input logic [2:0] v);
    @(negedge clk); st_clr = v;
    @(negedge clk); st_clr = '0;
  endtask

  task automatic count_pulses(input int n, input logic [15:0] p, input logic [15:0] o,
                              output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      smp(p, o);
      cnt += int'(mid_p);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R13 epin", int'(epin_o), 0);
    chk("R13 oe", int'(epin_oe && dpin_oe), 1);
    chk("R13 status", int'({st_pulse, st_dir, st_oor}), 0);
  endtask

  task automatic t_basic();
    do_reset();
    smp(16'h4000, 16'h0);
    chk("R1 first half", int'(mid_p), 0);
    smp(16'h4000, 16'h0);
    chk("R1 second half pulse", int'(mid_p), 1);
    chk("R7 one clock", int'(end_p), 0);
    chk("R3 pulse status", int'(st_pulse), 1);
    chk("R4 no dir positive", int'(st_dir), 0);
    smp(16'h0, 16'h0);
    chk("R5 auto clear", int'(st_pulse), 0);
    smp(16'h4000, 16'h0);
    smp(16'h4000, 16'h0);
    chk("R5 set again", int'(st_pulse), 1);
    host_clr(3'b001);
    chk("R5 host clear", int'(st_pulse), 0);
  endtask

  task automatic t_offset();
    int c;
    do_reset();
    count_pulses(4, 16'h0, 16'h4000, c);
    chk("R1 offset only", c, 2);
    do_reset();
    count_pulses(4, 16'h4000, 16'hC000, c);
    chk("R1 offset cancels", c, 0);
  endtask

  task automatic t_dir();
    do_reset();
    smp(16'hC000, 16'h0);
    smp(16'hC000, 16'h0);
    chk("R4 dir pin", int'({mid_p, mid_d}), 3);
    chk("R4 dir status", int'(st_dir), 1);
    smp(16'h0, 16'h0);
    chk("R5 dir auto clear", int'(st_dir), 0);
    smp(16'hC000, 16'h0);
    smp(16'hC000, 16'h0);
    host_clr(3'b010);
    chk("R5 dir host clear", int'({st_dir, st_pulse}), 1);
  endtask

  task automatic t_clamp();
    int c;
    do_reset();
    rate_cfg = 12'hFFF;
    count_pulses(8, 16'h0400, 16'h0, c);
    chk("R2 clamped rate", c, 2);
    chk("R2 no overrun", int'(st_oor), 0);
  endtask

  task automatic t_oor();
    do_reset();
    rate_cfg = 12'd64;
    smp(16'h7FFF, 16'h0001);
    chk("R6 pulse on overrun", int'(mid_p), 1);
    chk("R6 flag", int'(st_oor), 1);
    smp(16'h0, 16'h0);
    chk("R6 saturated below quantum", int'(mid_p), 0);
    chk("R6 sticky", int'(st_oor), 1);
    smp(16'h0001, 16'h0);
    chk("R6 saturated near quantum", int'(mid_p), 1);
    host_clr(3'b100);
    chk("R6 host clear", int'(st_oor), 0);
  endtask

  task automatic t_creep();
    int c;
    do_reset();
    count_pulses(8, 16'h2000, 16'h0, c);
    chk("R12 creep off", c, 2);
    do_reset();
    creep_en = 1'b1; creep_lim = 8'd3;
    count_pulses(8, 16'h2000, 16'h0, c);
    chk("R12 creep suppresses", c, 0);
  endtask

  task automatic t_mech();
    do_reset();
    mech_en = 1'b1; width_cfg = 10'd2;
    smp(16'h7FFF, 16'h0001); chk("R8 start", int'(end_p), 1);
    smp(16'h0, 16'h0);       chk("R8 held", int'(end_p), 1);
    smp(16'h0, 16'h0);       chk("R8 ends after width", int'(end_p), 0);
    do_reset();
    mech_en = 1'b1; width_cfg = 10'd2;
    smp(16'h7FFF, 16'h0001);
    smp(16'h7FFF, 16'h0001);
    smp(16'h0, 16'h0);       chk("R9 held request launched", int'(end_p), 1);
    smp(16'h0, 16'h0);       chk("R9 second pulse held", int'(end_p), 1);
    smp(16'h0, 16'h0);       chk("R9 second pulse ends", int'(end_p), 0);
    do_reset();
    mech_en = 1'b1; width_cfg = 10'd2;
    smp(16'h8000, 16'h0);    chk("R4 mech dir", int'({end_p, end_d}), 3);
    smp(16'h0, 16'h0);       chk("R4 mech dir held", int'(end_d), 1);
    smp(16'h0, 16'h0);       chk("R4 mech dir ends", int'(end_d), 0);
  endtask

  task automatic t_ovr();
    do_reset();
    ovr_en = 1'b1; ovr_pulse = 1'b1; ovr_dir = 1'b0;
    smp(16'hC000, 16'h0);
    smp(16'hC000, 16'h0);
    chk("R10 manual during pulse", int'({mid_p, mid_d}), 2);
    chk("R10 status still updates", int'(st_pulse), 1);
    ovr_pulse = 1'b0; ovr_dir = 1'b1; mech_en = 1'b1;
    smp(16'hC000, 16'h0);
    smp(16'hC000, 16'h0);
    chk("R10 manual beats mech", int'({mid_p, mid_d, end_p, end_d}), 5);
  endtask

  task automatic t_od();
    do_reset();
    ovr_en = 1'b1; odrain_en = 1'b1; ovr_pulse = 1'b1; ovr_dir = 1'b0;
    @(negedge clk);
    chk("R11 high released", int'({epin_o, epin_oe}), 0);
    chk("R11 low driven", int'({dpin_o, dpin_oe}), 1);
    ovr_pulse = 1'b0; ovr_dir = 1'b1;
    @(negedge clk);
    chk("R11 swap", int'({epin_o, epin_oe, dpin_o, dpin_oe}), 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_offset();
    t_dir();
    t_clamp();
    t_oor();
    t_creep();
    t_mech();
    t_ovr();
    t_od();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule